// File: doc/BRIEF.md
# Peripheral DMA Handshake Controller

This block sits between the endpoint FIFOs of a full-speed USB device and an external system DMA controller. It moves one byte per DMA cycle. It raises a request line when there is work to do, takes the acknowledge and data strobes from the system side, and pops or pushes the FIFO byte port once per completed strobe. A 16-bit down-counter holds the number of bytes still to move. The transfer ends when that counter runs out, when the system asserts an end-of-transfer during a strobe, or when a short packet is enabled as a terminator and its last byte leaves the FIFO.

Two handshake styles are available. In the qualified style, acknowledge must be active together with the read strobe (toward memory) or the write strobe (from memory). In the acknowledge-only style, acknowledge alone is the data strobe and the read and write pins play no part. Software programs the block through a two-register port: a control word and the byte counter. Reading the counter returns the remaining byte count.

Top module: `dma_handshake`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, `dreq` is low, `xfer_done` is low and no FIFO strobe is issued.
- R2: With the enable bit (control bit 0) set, a nonzero counter and `fifo_avail` high, the request becomes active one clock after the enable write takes effect. With `fifo_avail` low or a zero counter, the request stays inactive.
- R3: When control bit 2 is clear, the request pin is active high. When bit 2 is set, the pin idles high and is driven low when active.
- R4: With control bit 1 clear (qualified style), a byte completes only when `dack_n` is low together with the direction strobe. That strobe is `rd_n` when control bit 4 = 1 (FIFO to memory) and `wr_n` when bit 4 = 0. Acknowledge alone, or with the wrong strobe, moves no byte.
- R5: With control bit 1 set (acknowledge-only style), `dack_n` low alone is the strobe, and `rd_n` and `wr_n` have no effect at all.
- R6: The request drops in the clock after an active strobe is sampled. It rises again in the clock after acknowledge is released, provided bytes remain.
- R7: Each completed strobe (active then released) decrements the counter, and reading register 1 returns the remaining count. The byte that takes the count from 1 to 0 ends the transfer.
- R8: An end-of-transfer is accepted only when `eot_n` is low during an active strobe (acknowledge plus direction strobe, or acknowledge alone in acknowledge-only style). The transfer then ends when that byte completes. `eot_n` low without an active strobe has no effect.
- R9: With control bit 3 set and bit 4 = 1, completing a byte while `fifo_short_last` is high ends the transfer whatever the count. With bit 3 clear, `fifo_short_last` has no effect.
- R10: Any end of transfer produces a `xfer_done` pulse exactly one clock wide and clears the enable bit, in the same clock as the final counter update.
- R11: Clearing the enable bit takes the request to its inactive level in the same clock. A strobe in progress at that moment is discarded and does not change the counter.
- R12: Toward memory, `dma_dout` follows `fifo_rdata` and `fifo_rd_en` pulses for one clock as the strobe is released. From memory, the `dma_din` value held during the strobe appears on `fifo_wdata` with a one-clock `fifo_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled synchronously |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 counter |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| dreq | output | 1 | DMA request, polarity per control bit 2 |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| eot_n | input | 1 | End-of-transfer from system, active low |
| dma_din | input | 8 | Data from system bus (memory to FIFO) |
| dma_dout | output | 8 | Data to system bus (FIFO to memory) |
| fifo_avail | input | 1 | FIFO has a byte to read or room to write |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| fifo_short_last | input | 1 | Head byte is the last byte of a short packet |
| fifo_rd_en | output | 1 | Pop one byte from the FIFO |
| fifo_wr_en | output | 1 | Push one byte into the FIFO |
| fifo_wdata | output | 8 | Byte to push |
| xfer_done | output | 1 | One-clock end-of-transfer pulse |

## Verification
A register write takes effect at the clock edge where it is sampled, so the counter and control readback, a request disable and the immediate return of the request to its inactive level are all visible right after that edge. A newly enabled request shows one clock later. The request drops one clock after a strobe is sampled. When a strobe is released, the FIFO pulse is combinational in that same clock, while the counter decrement, the re-raised request, the cleared enable and the `xfer_done` pulse all appear after the next edge. The bench drives pins on falling edges, checks combinational results 1 ns after driving and registered results on the falling edge after the expected rising edge, and looks once more one clock later to confirm that the done pulse has gone.

// File: rtl/dma_hs_pkg.sv
// Package: shared types for the DMA handshake controller.
// Assumes the control word sits in the low bits of the register port.
package dma_hs_pkg;

    // Control word; the first member is the MSB, so en is bit 0.
    typedef struct packed {
        logic to_mem;    // bit 4: 1 = FIFO to memory (read strobe), 0 = memory to FIFO
        logic short_en;  // bit 3: short packet terminates the transfer
        logic req_low;   // bit 2: request pin active low
        logic ack_only;  // bit 1: acknowledge alone is the data strobe
        logic en;        // bit 0: DMA enable
    } dma_ctl_t;

    typedef enum logic {
        SEL_CTL = 1'b0,
        SEL_CNT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/dma_hs_regs.sv
// Module: dma_hs_regs
// Holds the control word and the remaining-byte counter. Register writes
// take priority over hardware updates in the same clock. Assumes
// CNT_W >= width of the control word.
module dma_hs_regs
    import dma_hs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    output logic [CNT_W-1:0] cfg_rdata,
    input  logic             byte_done_i,
    input  logic             xfer_end_i,
    output dma_ctl_t         ctl_o,
    output logic             cnt_one_o,
    output logic             cnt_zero_o
);
    localparam int CTL_W = $bits(dma_ctl_t);

    dma_ctl_t         ctl_q;
    logic [CNT_W-1:0] cnt_q;
    reg_sel_e         sel;
    logic             ctl_wr;
    logic             cnt_wr;

    assign sel    = reg_sel_e'(cfg_addr);
    assign ctl_wr = cfg_we && (sel == SEL_CTL);
    assign cnt_wr = cfg_we && (sel == SEL_CNT);

    // Control word: software write, else the enable is cleared at end of transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= dma_ctl_t'(cfg_wdata[CTL_W-1:0]);
        end else if (xfer_end_i) begin
            ctl_q.en <= 1'b0;
        end
    end

    // Counter: load from software, else count down once per completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= cfg_wdata;
        end else if (byte_done_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Readback mux.
    always_comb begin
        if (sel == SEL_CNT) cfg_rdata = cnt_q;
        else                cfg_rdata = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
    end

    assign ctl_o      = ctl_q;
    assign cnt_one_o  = (cnt_q == CNT_W'(1));
    assign cnt_zero_o = (cnt_q == '0);

    // R10
    end_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end_i && !ctl_wr) |=> !ctl_q.en);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_i && !cnt_wr && (cnt_q != '0)) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/dma_hs_strobe.sv
// Module: dma_hs_strobe
// Qualifies the acknowledge and read/write pins into one byte strobe. It
// detects strobe completion (active then released), latches inbound data,
// captures an end-of-transfer seen during a strobe, and decides whether
// the completing byte ends the transfer. Assumes all pins are synchronous
// to clk.
module dma_hs_strobe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ack_only_i,
    input  logic              to_mem_i,
    input  logic              short_en_i,
    input  logic              cnt_one_i,
    input  logic              dack_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic              eot_n_i,
    input  logic              short_last_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              strobe_o,
    output logic              dack_act_o,
    output logic              byte_done_o,
    output logic              xfer_end_o,
    output logic [DATA_W-1:0] din_q_o
);
    logic              dir_strobe;
    logic              strobe_q;
    logic              eot_seen_q;
    logic [DATA_W-1:0] din_q;

    assign dack_act_o  = en_i && !dack_n_i;
    assign dir_strobe  = to_mem_i ? !rd_n_i : !wr_n_i;
    assign strobe_o    = dack_act_o && (ack_only_i || dir_strobe);
    assign byte_done_o = en_i && strobe_q && !strobe_o;

    // Remember whether the strobe was active in the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_o;
    end

    // Capture an end-of-transfer that arrives together with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || byte_done_o) eot_seen_q <= 1'b0;
        else if (strobe_o && !eot_n_i)      eot_seen_q <= 1'b1;
    end

    // Hold inbound data while the strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)        din_q <= '0;
        else if (strobe_o) din_q <= din_i;
    end

    // The completing byte ends the transfer on count, external end, or short packet.
    always_comb begin
        xfer_end_o = byte_done_o &&
                     (cnt_one_i || eot_seen_q || (short_en_i && to_mem_i && short_last_i));
    end

    assign din_q_o = din_q;

    // R8
    eot_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done_o && eot_seen_q) |-> xfer_end_o);

    // R5
    ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ack_only_i && !dack_n_i) |-> strobe_o);

endmodule

// File: rtl/dma_hs_req.sv
// Module: dma_hs_req
// Generates the DMA request. The request drops once a strobe is seen and
// is re-armed only after acknowledge is released. It is gated by the
// enable bit and inverted when active-low polarity is selected.
module dma_hs_req (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic req_low_i,
    input  logic avail_i,
    input  logic cnt_zero_i,
    input  logic strobe_i,
    input  logic dack_act_i,
    output logic dreq_o
);
    logic req_q;
    logic req_act;

    // Request state: drop on strobe, hold while acknowledged, else re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n)          req_q <= 1'b0;
        else if (strobe_i)   req_q <= 1'b0;
        else if (!dack_act_i) req_q <= en_i && !cnt_zero_i && avail_i;
    end

    assign req_act = req_q && en_i;
    assign dreq_o  = req_act ^ req_low_i;

    // R6
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> !req_q);

    // R11
    req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (dreq_o == req_low_i));

endmodule

// File: rtl/dma_handshake.sv
// Module: dma_handshake (top)
// Device-side DMA request/acknowledge controller. It connects the
// register file, the strobe qualifier and the request generator, and
// drives the FIFO byte port. Assumes synchronous pins and a FIFO that
// accepts one pop or push per clock.
module dma_handshake
    import dma_hs_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    output logic [CNT_W-1:0]  cfg_rdata,
    output logic              dreq,
    input  logic              dack_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              eot_n,
    input  logic [DATA_W-1:0] dma_din,
    output logic [DATA_W-1:0] dma_dout,
    input  logic              fifo_avail,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_short_last,
    output logic              fifo_rd_en,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              xfer_done
);
    dma_ctl_t ctl;
    logic     cnt_one;
    logic     cnt_zero;
    logic     strobe;
    logic     dack_act;
    logic     byte_done;
    logic     xfer_end;
    logic     done_q;

    dma_hs_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .byte_done_i (byte_done),
        .xfer_end_i  (xfer_end),
        .ctl_o       (ctl),
        .cnt_one_o   (cnt_one),
        .cnt_zero_o  (cnt_zero)
    );

    dma_hs_strobe #(.DATA_W(DATA_W)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (ctl.en),
        .ack_only_i   (ctl.ack_only),
        .to_mem_i     (ctl.to_mem),
        .short_en_i   (ctl.short_en),
        .cnt_one_i    (cnt_one),
        .dack_n_i     (dack_n),
        .rd_n_i       (rd_n),
        .wr_n_i       (wr_n),
        .eot_n_i      (eot_n),
        .short_last_i (fifo_short_last),
        .din_i        (dma_din),
        .strobe_o     (strobe),
        .dack_act_o   (dack_act),
        .byte_done_o  (byte_done),
        .xfer_end_o   (xfer_end),
        .din_q_o      (fifo_wdata)
    );

    dma_hs_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctl.en),
        .req_low_i  (ctl.req_low),
        .avail_i    (fifo_avail),
        .cnt_zero_i (cnt_zero),
        .strobe_i   (strobe),
        .dack_act_i (dack_act),
        .dreq_o     (dreq)
    );

    // FIFO strobes follow the transfer direction on strobe completion.
    always_comb begin
        fifo_rd_en = byte_done && ctl.to_mem;
        fifo_wr_en = byte_done && !ctl.to_mem;
    end

    assign dma_dout = fifo_rdata;

    // Registered end-of-transfer pulse toward interrupt logic.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= xfer_end;
    end

    assign xfer_done = done_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R12
    fifo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_rd_en && fifo_wr_en));

endmodule

// File: tb/tb_dma_handshake.sv
module tb_dma_handshake;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        dreq;
    logic        dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
    logic [7:0]  dma_din = '0;
    logic [7:0]  dma_dout;
    logic        fifo_avail = 1'b1;
    logic [7:0]  fifo_rdata = '0;
    logic        fifo_short_last = 1'b0;
    logic        fifo_rd_en, fifo_wr_en;
    logic [7:0]  fifo_wdata;
    logic        xfer_done;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_handshake dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
        .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .eot_n(eot_n),
        .dma_din(dma_din), .dma_dout(dma_dout), .fifo_avail(fifo_avail),
        .fifo_rdata(fifo_rdata), .fifo_short_last(fifo_short_last),
        .fifo_rd_en(fifo_rd_en), .fifo_wr_en(fifo_wr_en),
        .fifo_wdata(fifo_wdata), .xfer_done(xfer_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [15:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    function automatic logic [15:0] ctlw(input logic en, ack, low, shrt, tomem);
        return {11'd0, tomem, shrt, low, ack, en};
    endfunction

    task automatic pins_idle();
        dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
    endtask

    // One full strobe: active for a clock, then released.
    task automatic strobe_byte(input logic ack_only, input logic to_mem, input logic eot,
                               output logic mid_dreq, output logic rdp, output logic wrp);
        dack_n = 1'b0;
        if (!ack_only) begin
            if (to_mem) rd_n = 1'b0; else wr_n = 1'b0;
        end
        eot_n = !eot;
        step();
        mid_dreq = dreq;
        pins_idle();
        #1;
        rdp = fifo_rd_en;
        wrp = fifo_wr_en;
        step();
    endtask

    task automatic quiesce();
        pins_idle();
        fifo_avail = 1'b1;
        fifo_short_last = 1'b0;
        wr_reg(1'b0, 16'h0000);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd_reg(1'b0, v); check("R1 ctl", v, 0);
        rd_reg(1'b1, v); check("R1 cnt", v, 0);
        check("R1 dreq", dreq, 0);
        check("R1 done", xfer_done, 0);
        check("R1 rd_en", fifo_rd_en, 0);
    endtask

    task automatic t_count_qualified();
        logic [15:0] v; logic m, r, w;
        fifo_rdata = 8'h3C;
        wr_reg(1'b1, 16'd2);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step();
        check("R2 dreq on", dreq, 1);
        check("R12 dout", dma_dout, 8'h3C);
        strobe_byte(0, 1, 0, m, r, w);
        check("R6 dreq drop", m, 0);
        check("R12 rd_en", r, 1);
        check("R12 no wr_en", w, 0);
        rd_reg(1'b1, v); check("R7 cnt 1", v, 1);
        check("R6 dreq re-raise", dreq, 1);
        check("R10 no early done", xfer_done, 0);
        strobe_byte(0, 1, 0, m, r, w);
        rd_reg(1'b1, v); check("R7 cnt 0", v, 0);
        check("R10 done pulse", xfer_done, 1);
        rd_reg(1'b0, v); check("R10 en cleared", v[0], 0);
        check("R7 dreq off at zero", dreq, 0);
        step();
        check("R10 pulse width", xfer_done, 0);
        quiesce();
    endtask

    task automatic t_qualify_strobes();
        logic [15:0] v;
        wr_reg(1'b1, 16'd3);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step();
        dack_n = 1'b0; step(); dack_n = 1'b1; step();
        rd_reg(1'b1, v); check("R4 dack alone", v, 3);
        dack_n = 1'b0; wr_n = 1'b0; step(); pins_idle(); step();
        rd_reg(1'b1, v); check("R4 wrong strobe", v, 3);
        quiesce();
    endtask

    task automatic t_ack_only();
        logic [15:0] v; logic m, r, w;
        wr_reg(1'b1, 16'd3);
        wr_reg(1'b0, ctlw(1, 1, 0, 0, 1));
        step();
        strobe_byte(1, 1, 0, m, r, w);
        rd_reg(1'b1, v); check("R5 dack strobe", v, 2);
        check("R5 rd_en", r, 1);
        rd_n = 1'b0; wr_n = 1'b0; step(); #1;
        check("R5 rw no pulse", fifo_rd_en, 0);
        rd_n = 1'b1; wr_n = 1'b1; step();
        rd_reg(1'b1, v); check("R5 rw ignored", v, 2);
        quiesce();
    endtask

    task automatic t_polarity();
        wr_reg(1'b0, ctlw(0, 0, 1, 0, 1));
        check("R3 idle high", dreq, 1);
        wr_reg(1'b1, 16'd2);
        wr_reg(1'b0, ctlw(1, 0, 1, 0, 1));
        step();
        check("R3 active low", dreq, 0);
        wr_reg(1'b0, ctlw(0, 0, 1, 0, 1));
        check("R11 disable immediate", dreq, 1);
        quiesce();
    endtask

    task automatic t_eot();
        logic [15:0] v; logic m, r, w;
        wr_reg(1'b1, 16'd5);
        wr_reg(1'b0, ctlw(1, 1, 0, 0, 1));
        step();
        eot_n = 1'b0; step(); step(); eot_n = 1'b1; step();
        rd_reg(1'b0, v); check("R8 lone eot en", v[0], 1);
        check("R8 lone eot done", xfer_done, 0);
        strobe_byte(1, 1, 1, m, r, w);
        rd_reg(1'b1, v); check("R8 cnt", v, 4);
        check("R8 done", xfer_done, 1);
        rd_reg(1'b0, v); check("R8 en cleared", v[0], 0);
        quiesce();
        wr_reg(1'b1, 16'd5);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        dack_n = 1'b0; eot_n = 1'b0; step(); pins_idle(); step();
        rd_reg(1'b0, v); check("R8 eot without rd", v[0], 1);
        quiesce();
    endtask

    task automatic t_short();
        logic [15:0] v; logic m, r, w;
        wr_reg(1'b1, 16'd10);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step();
        fifo_short_last = 1'b1;
        strobe_byte(0, 1, 0, m, r, w);
        check("R9 disabled no end", xfer_done, 0);
        rd_reg(1'b1, v); check("R9 cnt 9", v, 9);
        wr_reg(1'b0, ctlw(1, 0, 0, 1, 1));
        strobe_byte(0, 1, 0, m, r, w);
        check("R9 short end", xfer_done, 1);
        rd_reg(1'b1, v); check("R9 cnt 8", v, 8);
        rd_reg(1'b0, v); check("R9 en cleared", v[0], 0);
        quiesce();
    endtask

    task automatic t_abort();
        logic [15:0] v;
        wr_reg(1'b1, 16'd4);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step();
        check("R11 pre dreq", dreq, 1);
        dack_n = 1'b0; rd_n = 1'b0;
        wr_reg(1'b0, ctlw(0, 0, 0, 0, 1));
        check("R11 dreq off", dreq, 0);
        pins_idle(); #1;
        check("R11 no pop", fifo_rd_en, 0);
        step();
        rd_reg(1'b1, v); check("R11 cnt kept", v, 4);
        quiesce();
    endtask

    task automatic t_from_mem();
        logic [15:0] v;
        wr_reg(1'b1, 16'd2);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 0));
        step();
        dack_n = 1'b0; wr_n = 1'b0; dma_din = 8'hA5;
        step();
        pins_idle(); dma_din = 8'h00; #1;
        check("R12 wr_en", fifo_wr_en, 1);
        check("R12 wdata", fifo_wdata, 8'hA5);
        check("R12 no rd_en", fifo_rd_en, 0);
        step();
        rd_reg(1'b1, v); check("R7 from mem cnt", v, 1);
        quiesce();
    endtask

    task automatic t_gating();
        fifo_avail = 1'b0;
        wr_reg(1'b1, 16'd2);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step(); step();
        check("R2 no avail", dreq, 0);
        fifo_avail = 1'b1;
        step();
        check("R2 avail", dreq, 1);
        quiesce();
        wr_reg(1'b1, 16'd0);
        wr_reg(1'b0, ctlw(1, 0, 0, 0, 1));
        step(); step();
        check("R2 zero count", dreq, 0);
        quiesce();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_qualified();
        t_qualify_strobes();
        t_ack_only();
        t_polarity();
        t_eot();
        t_short();
        t_abort();
        t_from_mem();
        t_gating();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule